// File: doc/BRIEF.md
# Pixel Sample and Clamp Controller

This block turns the video-sample strobe and the reset-sample strobe of a two-input image-sensor front end into the per-pixel control events the analogue path needs. It runs on the master clock. Both strobes are sampled on its rising edge, and every event is derived from the sampled values. The events are:

- the clamp-switch enable;
- a one-cycle video capture pulse;
- a one-cycle bias-reference capture pulse;
- a one-cycle reset-level capture pulse, whose position a two-bit field can move;
- the two channel power enables;
- the odd/even selector that steers a shared converter.

Configuration arrives as already-decoded bits. These are the clamp enable, the clamp rule, correlated sampling on or off, the reset-capture position, the channel mode and the channel choice. The block also flags an illegal channel-mode code. It flags a reset strobe that rises while the video strobe is still high, or in the same sample where its fall is seen.

Top module: `pscc_pixel_timing`

## Requirements
- R1: While clamp_en_i is 0 at a rising edge, clamp_close_o is 0 in the following cycle, whatever the strobes do.
- R2: With clamp_en_i=1 and clamp_and_i=0, clamp_close_o in the cycle after an edge equals rsmp_i as sampled at that edge.
- R3: With clamp_en_i=1 and clamp_and_i=1, clamp_close_o in the cycle after an edge is 1 only if rsmp_i and vsmp_i were both 1 at that edge.
- R4: A video-strobe falling edge is an edge where vsmp_i is sampled 0 after being sampled 1 at the previous edge. video_cap_o is 1 for exactly the one cycle after that edge.
- R5: bias_cap_o pulses together with video_cap_o when cds_en_i was 0 at the detecting edge. It stays 0 when cds_en_i was 1.
- R6: A reset-strobe falling edge is detected in the same way as in R4. With cds_en_i=1, reset_cap_o is 1 a number of cycles after that edge set by rst_pos_i: code 00 gives one cycle, 01 two cycles (default), 10 three cycles and 11 four cycles. reset_cap_o is 0 while cds_en_i is 0.
- R7: chan_mode_i is coded as {mono, dual}. The enables registered from it are as follows:
  - 01: odd_en_o and even_en_o are both 1.
  - 10 with chan_sel_i=0: only odd_en_o is 1.
  - 10 with chan_sel_i=1: only even_en_o is 1.
  - 00 or 11: both enables are 0.
- R8: In mode 01, chan_even_o is 0 (odd) in the cycle after a video-strobe falling edge and 1 (even) in every other cycle. chan_sel_i has no effect in this mode.
- R9: In mode 10, chan_even_o follows chan_sel_i with one cycle of latency. In modes 00 and 11 it is 0.
- R10: mode_err_o is 1 in the cycle after any edge at which chan_mode_i is 11, and 0 otherwise.
- R11: With cds_en_i=1, early_err_o pulses for one cycle after an edge at which rsmp_i rises (0 before, 1 now) while vsmp_i is 1, or was 1 at the previous edge.
- R12: While rst is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| vsmp_i | input | 1 | Video-sample strobe |
| rsmp_i | input | 1 | Reset-sample strobe |
| clamp_en_i | input | 1 | Allows the clamp switch to close |
| clamp_and_i | input | 1 | Clamp rule: 0 = reset strobe, 1 = both strobes |
| cds_en_i | input | 1 | Correlated double sampling enable |
| rst_pos_i | input | 2 | Reset-capture position code |
| chan_mode_i | input | 2 | Channel mode {mono, dual} |
| chan_sel_i | input | 1 | Mono input choice: 0 odd, 1 even |
| clamp_close_o | output | 1 | Clamp switch closed |
| video_cap_o | output | 1 | Video capture pulse |
| bias_cap_o | output | 1 | Bias reference capture pulse |
| reset_cap_o | output | 1 | Reset level capture pulse |
| chan_even_o | output | 1 | Converter selector: 0 odd, 1 even |
| odd_en_o | output | 1 | Odd channel power enable |
| even_en_o | output | 1 | Even channel power enable |
| mode_err_o | output | 1 | Illegal channel-mode code |
| early_err_o | output | 1 | Reset strobe rose too early |

## Verification
The hardest case to reach from the ports is a reset-strobe fall whose capture, delayed four cycles, overlaps the next pixel. In that case the configuration may change and another fall may already be queued. The delayed pulse must then obey the position code and correlated-sampling setting in force when it emerges, not those in force when the fall occurred. The stimulus walks through every combination of the eight configuration bits with random strobe activity in each. This leaves falls in flight across configuration changes. A directed pixel adds a reset strobe that rises during the video strobe.

// File: rtl/pscc_pkg.sv
package pscc_pkg;

    // channel mode code, bit order {mono, dual}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_DUAL = 2'b01,
        MODE_MONO = 2'b10,
        MODE_BAD  = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic odd_en;
        logic even_en;
        logic sel_even;
    } chan_ctl_t;

    localparam int POS_W = 2;

    function automatic logic clamp_rule(input logic en, input logic both,
                                        input logic vs, input logic rs);
        return en & (both ? (vs & rs) : rs);
    endfunction

    function automatic chan_ctl_t chan_decode(input chan_mode_e m, input logic sel,
                                              input logic vfall);
        chan_ctl_t c;
        c = '0;
        case (m)
            MODE_DUAL: begin
                c.odd_en   = 1'b1;
                c.even_en  = 1'b1;
                c.sel_even = ~vfall;
            end
            MODE_MONO: begin
                c.odd_en   = ~sel;
                c.even_en  = sel;
                c.sel_even = sel;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pscc_strobe_edge.sv
module pscc_strobe_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] strobe_i,
    output logic [WIDTH-1:0] prev_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= strobe_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
        assign rise_o[i] = ~prev_q[i] & strobe_i[i];
        assign fall_o[i] = prev_q[i] & ~strobe_i[i];
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/pscc_reset_delay.sv
module pscc_reset_delay #(
    parameter int POS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             tap_o
);
    localparam int DEPTH = 1 << POS_W;

    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q[0] <= 1'b0;
        else     line_q[0] <= fall_i;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) line_q[k] <= 1'b0;
            else     line_q[k] <= line_q[k-1];
        end
    end

    assign tap_o = line_q[pos_i];

endmodule

// File: rtl/pscc_chan_ctrl.sv
module pscc_chan_ctrl
    import pscc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       sel_i,
    input  logic       vfall_i,
    output chan_ctl_t  ctl_o,
    output logic       mode_err_o
);
    chan_mode_e mode;
    chan_ctl_t  ctl_q;
    logic       err_q;

    assign mode = chan_mode_e'(mode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            err_q <= 1'b0;
        end else begin
            ctl_q <= chan_decode(mode, sel_i, vfall_i);
            err_q <= (mode == MODE_BAD);
        end
    end

    assign ctl_o      = ctl_q;
    assign mode_err_o = err_q;

    // R7
    both_en_only_dual_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.odd_en && ctl_q.even_en) |-> ($past(mode_i) == 2'b01));

    // R7
    mono_one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |=> $onehot({ctl_q.odd_en, ctl_q.even_en}));

    // R10
    mode_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> ($past(mode_i) == 2'b11));

    // R8
    dual_odd_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01 && vfall_i) |=> !ctl_q.sel_even);

endmodule

// File: rtl/pscc_pixel_timing.sv
module pscc_pixel_timing
    import pscc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsmp_i,
    input  logic       rsmp_i,
    input  logic       clamp_en_i,
    input  logic       clamp_and_i,
    input  logic       cds_en_i,
    input  logic [1:0] rst_pos_i,
    input  logic [1:0] chan_mode_i,
    input  logic       chan_sel_i,
    output logic       clamp_close_o,
    output logic       video_cap_o,
    output logic       bias_cap_o,
    output logic       reset_cap_o,
    output logic       chan_even_o,
    output logic       odd_en_o,
    output logic       even_en_o,
    output logic       mode_err_o,
    output logic       early_err_o
);
    localparam int NSTB = 2;
    localparam int VID  = 0;
    localparam int RSTB = 1;

    logic [NSTB-1:0] stb_prev, stb_rise, stb_fall;
    logic            clamp_q, vcap_q, bcap_q, early_q;
    logic            rtap;
    chan_ctl_t       ctl;

    pscc_strobe_edge #(.WIDTH(NSTB)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i ({rsmp_i, vsmp_i}),
        .prev_o   (stb_prev),
        .rise_o   (stb_rise),
        .fall_o   (stb_fall)
    );

    pscc_reset_delay #(.POS_W(POS_W)) u_rdly (
        .clk    (clk),
        .rst    (rst),
        .fall_i (stb_fall[RSTB]),
        .pos_i  (rst_pos_i),
        .tap_o  (rtap)
    );

    pscc_chan_ctrl u_chan (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (chan_mode_i),
        .sel_i      (chan_sel_i),
        .vfall_i    (stb_fall[VID]),
        .ctl_o      (ctl),
        .mode_err_o (mode_err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_q <= 1'b0;
            vcap_q  <= 1'b0;
            bcap_q  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            clamp_q <= clamp_rule(clamp_en_i, clamp_and_i, vsmp_i, rsmp_i);
            vcap_q  <= stb_fall[VID];
            bcap_q  <= stb_fall[VID] & ~cds_en_i;
            early_q <= cds_en_i & stb_rise[RSTB] & (vsmp_i | stb_prev[VID]);
        end
    end

    assign clamp_close_o = clamp_q;
    assign video_cap_o   = vcap_q;
    assign bias_cap_o    = bcap_q;
    assign reset_cap_o   = cds_en_i & rtap;
    assign early_err_o   = early_q;
    assign chan_even_o   = ctl.sel_even;
    assign odd_en_o      = ctl.odd_en;
    assign even_en_o     = ctl.even_en;

    // R1
    clamp_off_chk: assert property (@(posedge clk) disable iff (rst)
        !clamp_en_i |=> !clamp_close_o);

    // R3
    clamp_and_chk: assert property (@(posedge clk) disable iff (rst)
        (clamp_en_i && clamp_and_i && !(vsmp_i && rsmp_i)) |=> !clamp_close_o);

    // R4
    video_single_chk: assert property (@(posedge clk) disable iff (rst)
        video_cap_o |=> !video_cap_o);

    // R5
    bias_with_video_chk: assert property (@(posedge clk) disable iff (rst)
        bias_cap_o |-> video_cap_o);

    // R6
    reset_cap_cds_chk: assert property (@(posedge clk) disable iff (rst)
        reset_cap_o |-> cds_en_i);

    // R11
    early_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        early_err_o |-> $past(rsmp_i));

endmodule

// File: tb/tb_pscc_pixel_timing.sv
module tb_pscc_pixel_timing;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsmp = 1'b0, rsmp = 1'b0;
    logic       clamp_en = 1'b0, clamp_and = 1'b0, cds_en = 1'b0;
    logic [1:0] rst_pos = 2'b01, chan_mode = 2'b00;
    logic       chan_sel = 1'b0;

    logic clamp_close, video_cap, bias_cap, reset_cap, chan_even;
    logic odd_en, even_en, mode_err, early_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pscc_pixel_timing dut (
        .clk(clk), .rst(rst), .vsmp_i(vsmp), .rsmp_i(rsmp),
        .clamp_en_i(clamp_en), .clamp_and_i(clamp_and), .cds_en_i(cds_en),
        .rst_pos_i(rst_pos), .chan_mode_i(chan_mode), .chan_sel_i(chan_sel),
        .clamp_close_o(clamp_close), .video_cap_o(video_cap), .bias_cap_o(bias_cap),
        .reset_cap_o(reset_cap), .chan_even_o(chan_even), .odd_en_o(odd_en),
        .even_en_o(even_en), .mode_err_o(mode_err), .early_err_o(early_err)
    );

    // behavioural reference, updated at each rising edge
    bit m_vs, m_rs;
    bit e_clamp, e_video, e_bias, e_sel, e_odd, e_even, e_merr, e_early;
    bit hist[4];
    string clamp_tag, sel_tag;

    always @(posedge clk) begin
        if (rst) begin
            m_vs = 0; m_rs = 0;
            e_clamp = 0; e_video = 0; e_bias = 0; e_sel = 0;
            e_odd = 0; e_even = 0; e_merr = 0; e_early = 0;
            for (int i = 0; i < 4; i++) hist[i] = 0;
        end else begin
            bit vf, rf, rr;
            vf = m_vs && !vsmp;
            rf = m_rs && !rsmp;
            rr = !m_rs && rsmp;
            if (!clamp_en)      begin e_clamp = 0;             clamp_tag = "R1"; end
            else if (clamp_and) begin e_clamp = vsmp && rsmp;  clamp_tag = "R3"; end
            else                begin e_clamp = rsmp;          clamp_tag = "R2"; end
            e_video = vf;
            e_bias  = vf && !cds_en;
            e_early = cds_en && rr && (vsmp || m_vs);
            e_merr  = (chan_mode == 2'b11);
            if (chan_mode == 2'b01) begin
                e_odd = 1; e_even = 1; e_sel = !vf; sel_tag = "R8";
            end else if (chan_mode == 2'b10) begin
                e_odd = !chan_sel; e_even = chan_sel; e_sel = chan_sel; sel_tag = "R9";
            end else begin
                e_odd = 0; e_even = 0; e_sel = 0; sel_tag = "R9";
            end
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = rf;
            m_vs = vsmp; m_rs = rsmp;
        end
    end

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(clamp_tag, "clamp_close", clamp_close, e_clamp);
        chk("R4", "video_cap", video_cap, e_video);
        chk("R5", "bias_cap", bias_cap, e_bias);
        chk("R6", "reset_cap", reset_cap, cds_en && hist[rst_pos]);
        chk(sel_tag, "chan_even", chan_even, e_sel);
        chk("R7", "odd_en", odd_en, e_odd);
        chk("R7", "even_en", even_en, e_even);
        chk("R10", "mode_err", mode_err, e_merr);
        chk("R11", "early_err", early_err, e_early);
    endtask

    task automatic step(input logic vs, input logic rs);
        @(negedge clk);
        compare_all();
        vsmp = vs;
        rsmp = rs;
    endtask

    initial begin
        // R12: outputs while reset is held, with busy inputs
        vsmp = 1; rsmp = 1; clamp_en = 1; cds_en = 1; chan_mode = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "reset outputs",
            |{clamp_close, video_cap, bias_cap, reset_cap, chan_even,
              odd_en, even_en, mode_err, early_err}, 1'b0);
        vsmp = 0; rsmp = 0; chan_mode = 2'b01;
        rst = 0;

        // directed CDS pixel in dual mode, legal reset timing, position 11
        clamp_en = 1; clamp_and = 0; cds_en = 1; rst_pos = 2'b11;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(0, 1); step(0, 1); step(0, 0);
        repeat (6) step(0, 0);
        // R11: reset strobe rising while the video strobe is high
        step(1, 0); step(1, 1); step(0, 1); step(0, 0);
        repeat (6) step(0, 0);

        // sweep every configuration with random strobes
        for (int cfg = 0; cfg < 256; cfg++) begin
            {clamp_en, clamp_and, cds_en, rst_pos, chan_mode, chan_sel} = 8'(cfg);
            for (int c = 0; c < 12; c++)
                step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        // back-to-back 1:1 pixels in mono with a four-cycle reset delay
        clamp_en = 1; clamp_and = 1; cds_en = 1; rst_pos = 2'b11;
        chan_mode = 2'b10; chan_sel = 1;
        for (int p = 0; p < 20; p++) step(p[0], !p[0]);
        rst_pos = 2'b00;
        repeat (6) step(0, 0);

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule